// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request/acknowledge port and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. A requester raises `req` together with a direction, an address, write data and per-byte enables. The block then drives the memory pins through a fixed sequence of phases and pulses `ack` once the access is over. On a read, `rsp_rdata` holds the captured word from the `ack` cycle until the next read completes.

Each phase length is a whole number of clock cycles. It is derived at elaboration from the memory's timing limits in nanoseconds and the clock period `CLK_NS`: each limit is divided by the period and rounded up, with a floor of one cycle. Writes are ended by write enable rising. Reads are output-enable driven. The controller drives the shared data bus only while write enable is low. A write that follows a read first waits, with the bus released, for the memory to let go of the bus. Between accesses the memory is left deselected with both byte lanes disabled, which holds it in standby.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever no access is in progress: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_be_n` all ones, `mem_dq_oe`=0 and `ack`=0.
- R2: During a write, `mem_we_n` is low for exactly P = max(ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK)-1) consecutive cycles. `mem_dq_oe` is high in exactly those cycles. `mem_addr` and `mem_be_n` stay constant while the chip is selected.
- R3: A write with no turnaround selects the chip (`mem_ce1_n`=0, `mem_ce2`=1) for 1 + P + Q cycles, where Q = max(1, ceil(T_WC/CLK) - P - 1). This total is at least ceil(T_WC/CLK). `ack` rises in the cycle right after the chip is released.
- R4: Request byte enable bit 0 selects data bits 7:0 and bit 1 selects bits 15:8, with 1 meaning enabled. The matching `mem_be_n` bit is driven low. A write changes only the enabled lanes of the stored word.
- R5: A read holds `mem_oe_n` low and `mem_we_n` high for A = max(ceil(T_AA/CLK), ceil(T_DOE/CLK)) cycles. The bus is captured at the end of the last of those cycles, and `ack` with valid `rsp_rdata` follows in the next cycle.
- R6: In read data, lanes whose request byte enable was 0 are returned as zero.
- R7: A write whose previous access was a read keeps the chip selected with `mem_we_n` high and `mem_dq_oe` low for T = ceil(T_HZ/CLK) cycles before `mem_we_n` falls. A write after a write spends one cycle in that state.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low, and `mem_we_n` and `mem_oe_n` are never low together.
- R9: `ack` is high for exactly one cycle per access. `req` is sampled only in idle cycles where `ack` is low, so a request still held during the `ack` cycle does not start a second access.
- R10: `rsp_rdata` changes only in a cycle where `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until `ack` is seen |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte-lane enables, bit 0 = low lane, 1 = enabled |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data, disabled lanes zero |
| mem_addr | output | AW | Memory address pins |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_i | input | DW | Data sampled from the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | DW/8 | Active-low byte-lane enables |

## Verification
Two events can land on the same clock edge. The completion pulse of one access can coincide with a request that is still being held high. A read's release of output enable can be directly followed by a write that wants the bus. The bench holds `req` high through the `ack` cycle and then watches the pins and the access count to confirm no second access starts. It also issues a write immediately after a read, and checks the measured number of selected, write-high cycles before the write pulse as well as the overall latency. A memory model that returns corrupted data until the full access time has elapsed shows whether the capture lands exactly on the last access cycle.

// File: rtl/sram_ctl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM access sequencer.
// Assumes all timing inputs are given in whole nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WRECOV  = 3'd3,
        PH_RACCESS = 3'd4
    } phase_e;

    // Cycles covering a delay: round up, never less than one.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of the current phase.
// Assumes load is pulsed on the edge that enters a phase; last is high on the
// final cycle of that phase.
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: accepts a request when idle, walks the write or read phases,
// and issues the one-cycle completion pulse. It remembers whether the last
// access was a read so that a following write can insert the bus turnaround.
// Assumes every phase count is at least one.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned N_TA  = 3,
    parameter int unsigned N_PWE = 5,
    parameter int unsigned N_REC = 1,
    parameter int unsigned N_AA  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic          last,
    output phase_e        phase_q,
    output phase_e        phase_d,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture,
    output logic          ack
);

    logic ack_q;
    logic last_rd_q;
    logic done;
    int unsigned len;

    assign accept  = (phase_q == PH_IDLE) && req && !ack_q;
    assign capture = (phase_q == PH_RACCESS) && last;
    assign done    = last && ((phase_q == PH_WRECOV) || (phase_q == PH_RACCESS));
    assign ack     = ack_q;

    // Next phase and the length of the phase being entered.
    always_comb begin
        phase_d = phase_q;
        len     = 1;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        phase_d = PH_WSETUP;
                        len     = last_rd_q ? N_TA : 1;
                    end else begin
                        phase_d = PH_RACCESS;
                        len     = N_AA;
                    end
                end
            end
            PH_WSETUP: begin
                if (last) begin
                    phase_d = PH_WPULSE;
                    len     = N_PWE;
                end
            end
            PH_WPULSE: begin
                if (last) begin
                    phase_d = PH_WRECOV;
                    len     = N_REC;
                end
            end
            PH_WRECOV: begin
                if (last) phase_d = PH_IDLE;
            end
            PH_RACCESS: begin
                if (last) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign load     = (phase_d != phase_q);
    assign load_val = CW'(len - 1);

    // Phase register, completion pulse and last-access-was-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            ack_q     <= 1'b0;
            last_rd_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ack_q   <= done;
            if (accept) last_rd_q <= !req_write;
        end
    end

endmodule

// File: rtl/sram_data_path.sv
// Holds the accepted command and captures read data with disabled lanes zeroed.
// Assumes DW is a multiple of eight.
module sram_data_path #(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16,
    parameter int unsigned NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_be,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [NB-1:0] be_q,
    output logic [NB-1:0] be_sel,
    output logic [DW-1:0] rdata_q
);

    logic [DW-1:0] masked;

    // Per-lane masking of the sampled bus.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign masked[b*8 +: 8] = be_q[b] ? dq_i[b*8 +: 8] : 8'h00;
    end

    // Byte enables seen by the pin stage on the accepting edge.
    assign be_sel = accept ? req_be : be_q;

    // Latch the command on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Capture read data on the final access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= masked;
        end
    end

endmodule

// File: rtl/sram_pin_drive.sv
// Registered control pins, decoded from the phase being entered so that every
// pin changes on a clock edge and never glitches.
// Assumes be_sel already holds the lanes of the access in progress.
module sram_pin_drive
    import sram_ctl_pkg::*;
#(
    parameter int unsigned NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_d,
    input  logic [NB-1:0] be_sel,
    output logic          ce1_n,
    output logic          ce2,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe,
    output logic [NB-1:0] be_n
);

    // Pin levels for each phase; idle leaves the memory in standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce1_n <= 1'b1;
            ce2   <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            be_n  <= '1;
        end else begin
            ce1_n <= (phase_d == PH_IDLE);
            ce2   <= (phase_d != PH_IDLE);
            we_n  <= (phase_d != PH_WPULSE);
            oe_n  <= (phase_d != PH_RACCESS);
            dq_oe <= (phase_d == PH_WPULSE);
            be_n  <= (phase_d == PH_IDLE) ? '1 : ~be_sel;
        end
    end

endmodule

// File: rtl/sram_async_ctl.sv
// Top of the asynchronous SRAM access sequencer. Converts request/acknowledge
// commands into write-enable-ended writes and output-enable-driven reads.
// Assumes the requester holds req and its fields stable until ack.
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW        = 20,
    parameter int unsigned DW        = 16,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_WC_NS   = 45,
    parameter int unsigned T_PWE_NS  = 35,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_AW_NS   = 35,
    parameter int unsigned T_AA_NS   = 45,
    parameter int unsigned T_DOE_NS  = 22,
    parameter int unsigned T_HZ_NS   = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW/8-1:0]  req_be,
    output logic             ack,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_o,
    input  logic [DW-1:0]    mem_dq_i,
    output logic             mem_dq_oe,
    output logic             mem_ce1_n,
    output logic             mem_ce2,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [DW/8-1:0]  mem_be_n
);

    localparam int unsigned NB    = DW / 8;
    localparam int unsigned N_AWC = cyc_of(T_AW_NS, CLK_NS);
    localparam int unsigned N_PWE = max2(max2(cyc_of(T_PWE_NS, CLK_NS), cyc_of(T_SD_NS, CLK_NS)),
                                         (N_AWC > 1) ? N_AWC - 1 : 1);
    localparam int unsigned N_WC  = cyc_of(T_WC_NS, CLK_NS);
    localparam int unsigned N_REC = (N_WC > N_PWE + 1) ? N_WC - N_PWE - 1 : 1;
    localparam int unsigned N_AA  = max2(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_DOE_NS, CLK_NS));
    localparam int unsigned N_TA  = cyc_of(T_HZ_NS, CLK_NS);
    localparam int unsigned N_MAX = max2(max2(N_PWE, N_REC), max2(N_AA, N_TA));
    localparam int unsigned CW    = $clog2(N_MAX + 1);

    phase_e          phase_q;
    phase_e          phase_d;
    logic            load;
    logic            last;
    logic [CW-1:0]   load_val;
    logic            accept;
    logic            capture;
    logic [NB-1:0]   be_q;
    logic [NB-1:0]   be_sel;

    sram_seq_fsm #(
        .CW(CW), .N_TA(N_TA), .N_PWE(N_PWE), .N_REC(N_REC), .N_AA(N_AA)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .last(last),
        .phase_q(phase_q), .phase_d(phase_d), .load(load), .load_val(load_val),
        .accept(accept), .capture(capture), .ack(ack)
    );

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
    );

    sram_data_path #(.AW(AW), .DW(DW), .NB(NB)) u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .dq_i(mem_dq_i), .addr_q(mem_addr), .wdata_q(mem_dq_o),
        .be_q(be_q), .be_sel(be_sel), .rdata_q(rsp_rdata)
    );

    sram_pin_drive #(.NB(NB)) u_pins (
        .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .be_sel(be_sel),
        .ce1_n(mem_ce1_n), .ce2(mem_ce2), .we_n(mem_we_n), .oe_n(mem_oe_n),
        .dq_oe(mem_dq_oe), .be_n(mem_be_n)
    );

endmodule

// File: rtl/sram_async_ctl_chk.sv
// Protocol checker for the SRAM access sequencer, bound to its top module.
// Assumes N_PWE and N_TA match the phase counts of the bound instance.
module sram_async_ctl_chk #(
    parameter int unsigned AW    = 20,
    parameter int unsigned DW    = 16,
    parameter int unsigned N_PWE = 5,
    parameter int unsigned N_TA  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic [DW-1:0]   rsp_rdata,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_dq_oe,
    input logic            mem_ce1_n,
    input logic            mem_ce2,
    input logic            mem_we_n,
    input logic            mem_oe_n,
    input logic [DW/8-1:0] mem_be_n
);

    logic [15:0] we_lo_cnt;
    logic [15:0] oe_hi_cnt;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n) we_lo_cnt <= '0;
        else if (mem_we_n) we_lo_cnt <= '0;
        else if (we_lo_cnt != 16'hFFFF) we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    // Cycles since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_hi_cnt <= 16'hFFFF;
        else if (!mem_oe_n) oe_hi_cnt <= '0;
        else if (oe_hi_cnt != 16'hFFFF) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n |-> (!mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

    a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == 16'(N_PWE)));

    a_r2_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (oe_hi_cnt >= 16'(N_TA)));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    a_r8_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r10_rdata_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> ack);

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .AW(AW), .DW(DW), .N_PWE(N_PWE), .N_TA(N_TA)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_oe(mem_dq_oe), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
);

// File: tb/tb_sram_async_ctl.sv
// Directed bench for the SRAM access sequencer with a behavioural memory model
// that returns corrupted data until the full access time has elapsed.
module tb_sram_async_ctl;

    localparam int AW = 8;
    localparam int DW = 16;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CLKNS   = 8;
    localparam int EXP_P   = imax(imax(cdiv(35, CLKNS), cdiv(25, CLKNS)), cdiv(35, CLKNS) - 1);
    localparam int EXP_WC  = cdiv(45, CLKNS);
    localparam int EXP_Q   = imax(1, EXP_WC - EXP_P - 1);
    localparam int EXP_A   = imax(cdiv(45, CLKNS), cdiv(22, CLKNS));
    localparam int EXP_T   = cdiv(18, CLKNS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          ack;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;
    logic          mem_dq_oe;
    logic          mem_ce1_n;
    logic          mem_ce2;
    logic          mem_we_n;
    logic          mem_oe_n;
    logic [1:0]    mem_be_n;

    int total = 0;
    int bad = 0;

    sram_async_ctl #(.AW(AW), .DW(DW), .CLK_NS(CLKNS)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ack(ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
    );

    always #4 clk = ~clk;

    // Memory model.
    logic [15:0] mem [256];
    int          age = 0;
    logic        reading;
    logic        selected;
    logic [1:0]  mdrv;
    logic [15:0] mval;

    assign selected = !mem_ce1_n && mem_ce2;
    assign reading  = selected && !mem_oe_n && mem_we_n;
    assign mdrv     = reading ? ~mem_be_n : 2'b00;
    assign mval     = (age >= EXP_A) ? mem[mem_addr] : ~mem[mem_addr];
    assign mem_dq_i = {mdrv[1] ? mval[15:8] : 8'hA5, mdrv[0] ? mval[7:0] : 8'hA5};

    // Monitor state sampled between edges.
    int we_run = 0, last_we = 0;
    int sel_run = 0, last_sel = 0;
    int pre_run = 0, last_pre = 0;
    int starts = 0;
    int conflicts = 0;
    logic prev_ce1_n = 1'b1;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    end

    always @(negedge clk) begin
        age = reading ? age + 1 : 0;
        if (selected && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[0]) mem[mem_addr][7:0]  = mem_dq_o[7:0];
            if (!mem_be_n[1]) mem[mem_addr][15:8] = mem_dq_o[15:8];
        end
        if (mem_dq_oe && (mdrv != 2'b00)) conflicts++;
        if (!mem_we_n) we_run++;
        else if (we_run != 0) begin last_we = we_run; we_run = 0; end
        if (!mem_ce1_n) sel_run++;
        else if (sel_run != 0) begin last_sel = sel_run; sel_run = 0; end
        if (!mem_ce1_n && mem_we_n && mem_oe_n) pre_run++;
        else if (!mem_we_n && pre_run != 0) begin last_pre = pre_run; pre_run = 0; end
        else pre_run = 0;
        if (prev_ce1_n && !mem_ce1_n) starts++;
        prev_ce1_n = mem_ce1_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; returns read data and cycles from request to ack.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 100);
        rd = rsp_rdata;
        req = 1'b0;
        @(negedge clk);
        chk("R9 ack one cycle", {31'b0, ack}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 ce1_n", {31'b0, mem_ce1_n}, 32'h1);
        chk("R1 ce2", {31'b0, mem_ce2}, 32'h0);
        chk("R1 we/oe", {30'b0, mem_we_n, mem_oe_n}, 32'h3);
        chk("R1 be_n", {30'b0, mem_be_n}, 32'h3);
        chk("R1 dq_oe/ack", {30'b0, mem_dq_oe, ack}, 32'h0);
    endtask

    task automatic t_write_read();
        logic [15:0] rd; int lat;
        do_op(1'b1, 8'd5, 16'h1234, 2'b11, rd, lat);
        chk("R3 write latency", lat, 1 + 1 + EXP_P + EXP_Q);
        chk("R2 we low cycles", last_we, EXP_P);
        chk("R3 selected cycles", last_sel, 1 + EXP_P + EXP_Q);
        chk("R3 selected >= cycle time", {31'b0, last_sel >= EXP_WC}, 32'h1);
        chk("R7 write after write setup", last_pre, 1);
        do_op(1'b0, 8'd5, 16'h0, 2'b11, rd, lat);
        chk("R5 read latency", lat, 1 + EXP_A);
        chk("R5 read data", rd, 16'h1234);
        chk("R1 idle after access", {30'b0, mem_ce1_n, mem_ce2}, 32'h2);
    endtask

    task automatic t_byte_lanes();
        logic [15:0] rd; int lat;
        do_op(1'b1, 8'd9, 16'hAAAA, 2'b11, rd, lat);
        do_op(1'b1, 8'd9, 16'h1155, 2'b01, rd, lat);
        do_op(1'b0, 8'd9, 16'h0, 2'b11, rd, lat);
        chk("R4 low lane write", rd, 16'hAA55);
        do_op(1'b1, 8'd9, 16'h66FF, 2'b10, rd, lat);
        do_op(1'b0, 8'd9, 16'h0, 2'b11, rd, lat);
        chk("R4 high lane write", rd, 16'h6655);
    endtask

    task automatic t_partial_read();
        logic [15:0] rd; int lat;
        do_op(1'b0, 8'd9, 16'h0, 2'b10, rd, lat);
        chk("R6 high lane only", rd, 16'h6600);
        do_op(1'b0, 8'd9, 16'h0, 2'b01, rd, lat);
        chk("R6 low lane only", rd, 16'h0055);
    endtask

    task automatic t_turnaround();
        logic [15:0] rd; int lat;
        do_op(1'b0, 8'd5, 16'h0, 2'b11, rd, lat);
        do_op(1'b1, 8'd6, 16'hBEEF, 2'b11, rd, lat);
        chk("R7 turnaround cycles", last_pre, EXP_T);
        chk("R7 write latency after read", lat, 1 + EXP_T + EXP_P + EXP_Q);
        do_op(1'b0, 8'd6, 16'h0, 2'b11, rd, lat);
        chk("R7 data after turnaround", rd, 16'hBEEF);
    endtask

    task automatic t_patterns();
        logic [15:0] rd; int lat;
        for (int i = 0; i < 6; i++) begin
            do_op(1'b1, AW'(16 + i), 16'h3C00 ^ 16'(i * 16'h0111), 2'b11, rd, lat);
        end
        for (int i = 5; i >= 0; i--) begin
            do_op(1'b0, AW'(16 + i), 16'h0, 2'b11, rd, lat);
            chk("R5 pattern read", rd, 16'h3C00 ^ 16'(i * 16'h0111));
        end
    endtask

    task automatic t_ack_guard();
        int s0; int waited;
        s0 = starts;
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = 8'd5; req_be = 2'b11;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!ack && waited < 100);
        @(posedge clk);
        #1 req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9 no access after held req", {30'b0, mem_ce1_n, ack}, 32'h2);
        end
        chk("R9 single access started", starts - s0, 1);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_read();
        t_byte_lanes();
        t_partial_read();
        t_turnaround();
        t_patterns();
        t_ack_guard();
        chk("R8 no bus contention", conflicts, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule